// File: doc/BRIEF.md
# Shared Memory Section Bus Arbiter

This block grants one shared data-memory section to one of several bus masters at a time. Master 0 is the processor, master 1 is the DMA read side and master 2 is the DMA write side. Any masters from index 3 upward are extra masters. Each master drives a request, a burst flag and a done strobe. The arbiter drives a one-hot grant vector.

The order of service follows the state of each access. A master that holds the bus keeps it until it signals done, whether it is doing a single access or a burst. While the bus is free, a request for a burst beats a request for a single access. Inside one class the processor wins first. Contention between the two DMA sides alternates. Extra masters come last, with the lower index first. The chip places one instance in front of each memory section, so masters aimed at different sections are served at the same time with no interaction.

A grant is registered. A request seen at a clock edge while the bus is free is granted by that edge. The edge that sees done from the holder clears the grant. Arbitration resumes in the following cycle.

Top module: `sec_bus_arbiter`

## Requirements
- R1: After synchronous active-high reset the grant vector is all zero, and the first DMA read/write contention goes to DMA read (master 1).
- R2: A granted master keeps its grant, unchanged, in every cycle until it asserts its own done bit, whatever any other master requests.
- R3: The clock edge that samples done from the holder clears the grant. The bus then stays ungranted for that one cycle, and a new winner is granted at the following edge.
- R4: While the bus is free, any master requesting with burst=1 is granted ahead of every master requesting with burst=0, the processor included.
- R5: Within the winning class (burst or single), the processor (master 0) wins whenever it requests.
- R6: Within the winning class, when both DMA sides (masters 1 and 2) request and the processor does not, the grant goes to the DMA side not granted most recently. A grant to master 1 gives the next tie to master 2, and a grant to master 2 gives it back to master 1.
- R7: Extra masters (index 3 and above) win only when no processor or DMA master is in the winning class. Among them the lowest index wins.
- R8: The grant vector is always one-hot or all-zero.
- R9: Done bits from masters that do not hold the grant have no effect on the grant.
- R10: While the bus is free, a grant is issued at the next edge if and only if some master requests, and it is issued only to a master that requested at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NUM_MASTERS | Per-master access request |
| burst_i | input | NUM_MASTERS | Per-master flag: the requested access is a burst |
| done_i | input | NUM_MASTERS | Per-master strobe: single access or last burst beat finished |
| grant_o | output | NUM_MASTERS | One-hot grant, all zero while the bus is free |

## Verification
The hidden state is the holder, the access kind and the DMA preference bit. A lost holder shows at the ports within one cycle, as a grant that drops or moves while another master requests or a foreign done arrives. A wrong preference bit does not appear until the next tie between the two DMA sides, so the sweep runs all request and burst patterns back to back and carries a model of the preference across them. Any bad tie-break then shows on the first contended pattern that follows.

// File: rtl/sbarb_pkg.sv
package sbarb_pkg;

    localparam int CPU_IDX   = 0;
    localparam int DMA_RD    = 1;
    localparam int DMA_WR    = 2;
    localparam int EXTRA_LO  = 3;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_SINGLE = 2'd1,
        ACC_BURST  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      pref_wr;   // 1: next DMA tie goes to the write side
    } arb_state_t;

    function automatic logic is_dma(input int idx);
        return (idx == DMA_RD) || (idx == DMA_WR);
    endfunction

endpackage

// File: rtl/sbarb_classify.sv
module sbarb_classify #(
    parameter int NUM_MASTERS = 4
) (
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [NUM_MASTERS-1:0] burst_i,
    output logic [NUM_MASTERS-1:0] cand_o,
    output logic                   is_burst_o
);
    logic [NUM_MASTERS-1:0] burst_req;
    logic [NUM_MASTERS-1:0] single_req;

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_cls
        assign burst_req[g]  = req_i[g] & burst_i[g];
        assign single_req[g] = req_i[g] & ~burst_i[g];
    end

    assign is_burst_o = |burst_req;
    assign cand_o     = is_burst_o ? burst_req : single_req;
endmodule

// File: rtl/sbarb_pick.sv
module sbarb_pick
    import sbarb_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic [NUM_MASTERS-1:0] cand_i,
    input  logic                   pref_wr_i,
    output logic [NUM_MASTERS-1:0] win_o
);
    always_comb begin
        logic found;
        win_o = '0;
        found = 1'b0;
        if (cand_i[CPU_IDX]) begin
            win_o[CPU_IDX] = 1'b1;
        end else if (cand_i[DMA_RD] && cand_i[DMA_WR]) begin
            if (pref_wr_i) win_o[DMA_WR] = 1'b1;
            else           win_o[DMA_RD] = 1'b1;
        end else if (cand_i[DMA_RD]) begin
            win_o[DMA_RD] = 1'b1;
        end else if (cand_i[DMA_WR]) begin
            win_o[DMA_WR] = 1'b1;
        end else begin
            for (int i = EXTRA_LO; i < NUM_MASTERS; i++) begin
                if (cand_i[i] && !found) begin
                    win_o[i] = 1'b1;
                    found    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sbarb_hold.sv
module sbarb_hold
    import sbarb_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [NUM_MASTERS-1:0] done_i,
    input  logic [NUM_MASTERS-1:0] win_i,
    input  logic                   win_burst_i,
    output logic [NUM_MASTERS-1:0] grant_o,
    output logic                   pref_wr_o
);
    arb_state_t             st_q;
    logic [NUM_MASTERS-1:0] grant_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q    <= '0;
            st_q.kind  <= ACC_IDLE;
            st_q.pref_wr <= 1'b0;
        end else if (st_q.kind == ACC_IDLE) begin
            if (|req_i) begin
                grant_q   <= win_i;
                st_q.kind <= win_burst_i ? ACC_BURST : ACC_SINGLE;
                if (win_i[DMA_RD]) st_q.pref_wr <= 1'b1;
                if (win_i[DMA_WR]) st_q.pref_wr <= 1'b0;
            end
        end else if (|(grant_q & done_i)) begin
            grant_q   <= '0;
            st_q.kind <= ACC_IDLE;
        end
    end

    assign grant_o   = grant_q;
    assign pref_wr_o = st_q.pref_wr;
endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter #(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [NUM_MASTERS-1:0] burst_i,
    input  logic [NUM_MASTERS-1:0] done_i,
    output logic [NUM_MASTERS-1:0] grant_o
);
    logic [NUM_MASTERS-1:0] cand;
    logic [NUM_MASTERS-1:0] win;
    logic                   cand_burst;
    logic                   pref_wr;

    sbarb_classify #(.NUM_MASTERS(NUM_MASTERS)) u_cls (
        .req_i     (req_i),
        .burst_i   (burst_i),
        .cand_o    (cand),
        .is_burst_o(cand_burst)
    );

    sbarb_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
        .cand_i   (cand),
        .pref_wr_i(pref_wr),
        .win_o    (win)
    );

    sbarb_hold #(.NUM_MASTERS(NUM_MASTERS)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .done_i     (done_i),
        .win_i      (win),
        .win_burst_i(cand_burst),
        .grant_o    (grant_o),
        .pref_wr_o  (pref_wr)
    );
endmodule

// File: rtl/sec_bus_arbiter_chk.sv
module sec_bus_arbiter_chk #(
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_MASTERS-1:0] req_i,
    input logic [NUM_MASTERS-1:0] burst_i,
    input logic [NUM_MASTERS-1:0] done_i,
    input logic [NUM_MASTERS-1:0] grant_o
);
    assert_onehot_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    assert_hold_until_done_R2: assert property (@(posedge clk) disable iff (rst)
        (grant_o != '0) && !(|(grant_o & done_i)) |=> grant_o == $past(grant_o));

    assert_release_on_done_R3: assert property (@(posedge clk) disable iff (rst)
        |(grant_o & done_i) |=> grant_o == '0);

    assert_grant_to_requester_R10: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0) && (|req_i) |=> |(grant_o & $past(req_i)));

    assert_no_spurious_grant_R10: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0) && !(|req_i) |=> grant_o == '0);

    assert_burst_first_R4: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0) && (|(req_i & burst_i)) |=> |(grant_o & $past(req_i & burst_i)));

    assert_cpu_first_R5: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0) && req_i[0] && (burst_i[0] || !(|(req_i & burst_i))) |=> grant_o[0]);
endmodule

bind sec_bus_arbiter sec_bus_arbiter_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .burst_i(burst_i),
    .done_i (done_i),
    .grant_o(grant_o)
);

// File: tb/sec_bus_arbiter_test.sv
module sec_bus_arbiter_test;
    localparam int N = 4;
    localparam time HALF = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] burst = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] grant;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic pref_wr_m = 1'b0;

    sec_bus_arbiter #(.NUM_MASTERS(N)) uut (
        .clk(clk), .rst(rst), .req_i(req), .burst_i(burst),
        .done_i(done), .grant_o(grant)
    );

    always #HALF clk = ~clk;

    // Score-based model: class weight, then rank within class.
    function automatic logic [N-1:0] model(input logic [N-1:0] r,
                                           input logic [N-1:0] b,
                                           input logic pw);
        int best_i = -1;
        int best_s = -1;
        for (int i = 0; i < N; i++) begin
            int s;
            if (!r[i]) continue;
            s = b[i] ? 100 : 0;
            if (i == 0)      s += 50;
            else if (i == 1) s += pw ? 40 : 45;
            else if (i == 2) s += pw ? 45 : 40;
            else             s += 30 - i;
            if (s > best_s) begin best_s = s; best_i = i; end
        end
        return (best_i < 0) ? '0 : (N'(1) << best_i);
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic note_grant(input logic [N-1:0] g);
        if (g[1]) pref_wr_m = 1'b1;
        if (g[2]) pref_wr_m = 1'b0;
    endtask

    initial begin
        logic [N-1:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset grant", grant, '0);

        // R1 and R6: first DMA tie goes to read, then alternates
        for (int k = 0; k < 3; k++) begin
            e = (k % 2 == 0) ? 4'b0010 : 4'b0100;
            req = 4'b0110; burst = '0; done = '0;
            @(negedge clk);
            check("R1 R6 DMA alternation", grant, e);
            note_grant(grant);
            req = '0; done = e;
            @(negedge clk);
            done = '0;
        end

        // R3: release, one free cycle, then next winner
        req = 4'b1001; burst = '0;
        @(negedge clk);
        check("R5 cpu single", grant, 4'b0001);
        done = 4'b0001;
        @(negedge clk);
        done = '0;
        check("R3 free cycle after done", grant, '0);
        req = 4'b1000;
        @(negedge clk);
        check("R3 R7 regrant next edge", grant, 4'b1000);
        req = '0; done = 4'b1000;
        @(negedge clk);
        done = '0;

        // Sweep of all request and burst patterns
        for (int r = 0; r < 16; r++) begin
            for (int b = 0; b < 16; b++) begin
                req = N'(r); burst = N'(b); done = '0;
                e = model(N'(r), N'(b), pref_wr_m);
                @(negedge clk);
                check("R4 R5 R6 R7 R10 winner", grant, e);
                checks++;
                if ($countones(grant) > 1) begin
                    errors++;
                    $display("FAIL R8: grant=%b expected=onehot0", grant);
                end
                if (e == '0) continue;
                note_grant(e);
                req = ~N'(r); done = ~e;
                @(negedge clk);
                check("R2 R9 hold against others", grant, e);
                req = '0; done = e;
                @(negedge clk);
                done = '0;
                check("R3 release on done", grant, '0);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule